// File: doc/BRIEF.md
# Two-Wire Transition-Coded Link Receiver

This block receives a serial link carried on two data wires. The wires carry no clock. A bit is signalled by a change of level on one of the wires. A change on the first wire means a 0 bit, and a change on the second wire means a 1 bit. The direction of the change does not matter. The receiver answers every accepted bit by flipping a returned acknowledge wire. The sender waits for that flip before it sends the next bit, so the link keeps working whatever the wire delays are.

Both wires pass through a two-stage synchroniser. Each synchronised level is then compared with the last level the receiver recorded for that wire. Each bit enters the top of a ten-bit shift register, so the first bit received ends up in bit 0 of the token. When the tenth bit arrives, the finished token is presented with a one-cycle valid pulse. If both wires change in the same sampled cycle, the receiver raises an error pulse and accepts no bit.

Top module: `trans_link_rx`

## Requirements
- R1: After reset, `ackOut`, `tokenValid`, `protoErr` and `tokenData` are all 0. The recorded levels of both wires are also 0.
- R2: A level change on `wireZero` alone is accepted as a 0 bit. A rising change and a falling change are treated the same.
- R3: A level change on `wireOne` alone is accepted as a 1 bit. A rising change and a falling change are treated the same.
- R4: Bits are assembled LSB-first. The first bit of a token appears in `tokenData[0]` and the tenth bit appears in `tokenData[9]`.
- R5: `ackOut` inverts exactly once for each accepted bit. It changes on the third rising clock edge after the input change.
- R6: Every tenth accepted bit completes a token. On completion, `tokenValid` is high for exactly one cycle, and `tokenData` keeps the token until the next completion.
- R7: If both wires change in the same sampled cycle, `protoErr` pulses for one cycle. No bit is accepted, `ackOut` does not change, and the bit count of the token is unaffected.
- R8: While neither wire changes, `ackOut`, `tokenValid` and `protoErr` stay unchanged and low as appropriate.
- R9: The recorded wire levels carry over from one token to the next. The first bit of a new token is a change relative to the levels left by the previous token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wireZero | input | 1 | Asynchronous data wire; a level change means a 0 bit |
| wireOne | input | 1 | Asynchronous data wire; a level change means a 1 bit |
| ackOut | output | 1 | Acknowledge wire; inverts once per accepted bit |
| tokenData | output | 10 | Last completed token, bit 0 received first |
| tokenValid | output | 1 | One-cycle pulse when a token completes |
| protoErr | output | 1 | One-cycle pulse when both wires change together |

## Verification
All 1024 token values are sent back to back, without reset or any return of the wires to a known level. This exercises both change directions on both wires and the carry-over of recorded levels between tokens. It also shows whether any bit position is misplaced, because every token value is compared in full. The acknowledge flip is checked after each bit, which separates a missed or doubled bit from a wrong shift. A simultaneous change on both wires, inserted between tokens, shows that the error path does not consume a bit. An idle stretch shows that a held level produces no activity.

// File: rtl/trans_link_pkg.sv
package trans_link_pkg;
  typedef struct packed {
    logic shiftEn;   // one bit accepted this cycle
    logic bitVal;    // value of the accepted bit
    logic complete;  // accepted bit is the last of a token
  } linkStrobe_t;
endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= asyncIn;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/link_rx_ctrl.sv
module link_rx_ctrl
  import trans_link_pkg::*;
#(
  parameter int TOKEN_BITS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  wireSync,
  output linkStrobe_t strobe,
  output logic        protoErr
);
  localparam int CNT_W = $clog2(TOKEN_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOKEN_BITS - 1);

  logic [1:0]       seenLvl;
  logic [1:0]       change;
  logic [CNT_W-1:0] bitCnt;

  assign change = wireSync ^ seenLvl;

  always_comb begin
    strobe.shiftEn  = change[0] ^ change[1];
    strobe.bitVal   = change[1];
    strobe.complete = strobe.shiftEn && (bitCnt == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenLvl  <= '0;
      bitCnt   <= '0;
      protoErr <= 1'b0;
    end else begin
      seenLvl  <= wireSync;
      protoErr <= &change;
      if (strobe.complete)     bitCnt <= '0;
      else if (strobe.shiftEn) bitCnt <= bitCnt + 1'b1;
    end
  end

  // Bit counter never leaves the token range
  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= LAST_IDX);

  // A double change leaves the count of the token untouched
  assert_err_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&change) |=> $stable(bitCnt));

  // With no change the recorded levels are kept
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (change == 2'b00) |=> $stable(seenLvl));
endmodule

// File: rtl/link_rx_dp.sv
module link_rx_dp
  import trans_link_pkg::*;
#(
  parameter int TOKEN_BITS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  linkStrobe_t           strobe,
  output logic                  ackOut,
  output logic [TOKEN_BITS-1:0] tokenData,
  output logic                  tokenValid
);
  logic [TOKEN_BITS-1:0] shiftReg;
  logic [TOKEN_BITS-1:0] shiftNext;

  assign shiftNext = {strobe.bitVal, shiftReg[TOKEN_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg   <= '0;
      ackOut     <= 1'b0;
      tokenData  <= '0;
      tokenValid <= 1'b0;
    end else begin
      tokenValid <= strobe.complete;
      if (strobe.shiftEn) begin
        ackOut <= ~ackOut;
        if (strobe.complete) begin
          tokenData <= shiftNext;
          shiftReg  <= '0;
        end else begin
          shiftReg  <= shiftNext;
        end
      end
    end
  end

  // Every accepted bit flips the acknowledge exactly once
  assert_ack_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.shiftEn |=> (ackOut != $past(ackOut)));

  assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.shiftEn |=> $stable(ackOut));

  // Token valid is a single-cycle pulse and data is held between tokens
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tokenValid |=> !tokenValid);

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.complete |=> $stable(tokenData));
endmodule

// File: rtl/trans_link_rx.sv
module trans_link_rx
  import trans_link_pkg::*;
#(
  parameter int TOKEN_BITS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wireZero,
  input  logic                  wireOne,
  output logic                  ackOut,
  output logic [TOKEN_BITS-1:0] tokenData,
  output logic                  tokenValid,
  output logic                  protoErr
);
  logic [1:0]  wireSync;
  linkStrobe_t strobe;

  link_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({wireOne, wireZero}), .syncOut(wireSync)
  );

  link_rx_ctrl #(.TOKEN_BITS(TOKEN_BITS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wireSync(wireSync),
    .strobe(strobe), .protoErr(protoErr)
  );

  link_rx_dp #(.TOKEN_BITS(TOKEN_BITS)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .ackOut(ackOut), .tokenData(tokenData), .tokenValid(tokenValid)
  );

  // A protocol error never coincides with an acknowledge flip
  assert_err_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    protoErr |-> $stable(ackOut));

  assert_err_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    protoErr |-> !tokenValid);
endmodule

// File: tb/trans_link_rx_tb.sv
`timescale 1ns/1ps
module trans_link_rx_tb_top;
  localparam int NBITS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wireZero = 1'b0;
  logic wireOne = 1'b0;
  logic ackOut, tokenValid, protoErr;
  logic [NBITS-1:0] tokenData;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  trans_link_rx dut_i (
    .clk(clk), .rst_n(rst_n), .wireZero(wireZero), .wireOne(wireOne),
    .ackOut(ackOut), .tokenData(tokenData), .tokenValid(tokenValid),
    .protoErr(protoErr)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Send one bit, wait four cycles, count valid pulses, check ack flip (R5)
  task automatic sendBit(input logic b, output int validSeen);
    logic prevAck;
    prevAck = ackOut;
    if (b) wireOne = ~wireOne;   // R3
    else   wireZero = ~wireZero; // R2
    validSeen = 0;
    repeat (4) begin
      @(negedge clk);
      if (tokenValid) validSeen++;
    end
    check(ackOut == ~prevAck, "R5 ack flip per bit", int'(ackOut), int'(~prevAck));
  endtask

  task automatic sendToken(input logic [NBITS-1:0] val, input string req);
    int vs;
    int vTotal;
    vTotal = 0;
    for (int i = 0; i < NBITS; i++) begin
      sendBit(val[i], vs);
      vTotal += vs;
    end
    check(vTotal == 1, "R6 one valid pulse per token", vTotal, 1);
    check(tokenData == val, req, int'(tokenData), int'(val));
  endtask

  initial begin
    int errSeen;
    logic prevAck;
    logic [NBITS-1:0] held;

    repeat (3) @(negedge clk);
    check(ackOut == 1'b0, "R1 ack reset", int'(ackOut), 0);
    check(tokenValid == 1'b0, "R1 valid reset", int'(tokenValid), 0);
    check(protoErr == 1'b0, "R1 err reset", int'(protoErr), 0);
    check(tokenData == '0, "R1 data reset", int'(tokenData), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: idle wires produce nothing
    prevAck = ackOut;
    errSeen = 0;
    repeat (20) begin
      @(negedge clk);
      if (tokenValid || protoErr || ackOut != prevAck) errSeen++;
    end
    check(errSeen == 0, "R8 idle no activity", errSeen, 0);

    // R4: lone first bit lands in bit 0, lone last bit in bit 9
    sendToken(10'h001, "R4 first bit to LSB");
    sendToken(10'h200, "R4 last bit to MSB");

    // R7: double change between tokens, then a token must still be whole
    prevAck = ackOut;
    held = tokenData;
    wireZero = ~wireZero;
    wireOne = ~wireOne;
    errSeen = 0;
    repeat (4) begin
      @(negedge clk);
      if (protoErr) errSeen++;
    end
    check(errSeen == 1, "R7 error pulse", errSeen, 1);
    check(ackOut == prevAck, "R7 no ack on error", int'(ackOut), int'(prevAck));
    check(tokenData == held, "R7 data held on error", int'(tokenData), int'(held));
    sendToken(10'h2A5, "R7 no bit consumed by error");

    // R7: double change in mid-token
    for (int i = 0; i < 5; i++) begin
      int vs;
      sendBit(1'(i & 1), vs);
    end
    wireZero = ~wireZero;
    wireOne = ~wireOne;
    repeat (4) @(negedge clk);
    for (int i = 5; i < NBITS; i++) begin
      int vs;
      sendBit(1'b1, vs);
    end
    check(tokenData == 10'h3EA, "R7 mid-token error skipped", int'(tokenData), 10'h3EA);

    // R2 R3 R4 R9: exhaustive sweep, wire levels carried across tokens
    for (int v = 0; v < (1 << NBITS); v++)
      sendToken(NBITS'(v), "R9 R2 R3 sweep token value");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule